// File: doc/BRIEF.md
# Multi-Mode Interval, Event and Capture Timer

This block is an 8-bit up-counter that serves three jobs, chosen by a mode field. As an interval timer it counts prescaled clock ticks. At the top of its range it either wraps to zero or reloads a software preset. As an event counter it counts selected edges of an external pin. As a capture timer it measures the spacing between trigger edges on that pin. On each trigger it stores the elapsed count and restarts from zero.

Software uses a small register port: one write strobe with an address, and a combinational read mux. A sticky interrupt request flag is raised on every overflow and every capture. In capture mode, two further sticky flags report that a capture is pending and that a measurement was lost. The external pin is asynchronous and passes through a synchronizer before edge detection.

The mode field is held in a state register with four named states: FREE (wrap to zero), RELOAD (wrap to preset), EVENT (count pin edges) and CAPTURE (measure pin edges). The only transition is a write to the control register. It moves the block to the state encoded in the written data, from any state to any state, and the move takes effect on the next clock edge.

Top module: `tick_capture_timer`

## Requirements
- R1: After reset, the counter, preset, control, flags and capture registers all read 0 and `irq_flag` is low.
- R2: A write to address 0 loads both the preset and the counter on the next edge. After that, the counter rises by one on each selected tick. In the three clock-driven modes the tick comes once every 2^S clock cycles, where S is control bits [4:2]. The tick divider restarts on every control write.
- R3: A tick that arrives while the count is 0xFF is an overflow. It sets the count to the preset in RELOAD mode (control bits [1:0] = 01) and to 0x00 in FREE (00), EVENT (10) and CAPTURE (11) modes.
- R4: Every overflow and every capture sets flag bit 0, which also drives `irq_flag`. The bit stays set until software writes 0 to it at address 2. Writing 1 to it has no effect.
- R5: In EVENT mode, each selected pin edge is one tick. Control bits [6:5] choose the edge: 01 rising, 10 falling, 11 both, 00 none (pin ignored). The count changes on the third rising clock edge after the pin changes.
- R6: In CAPTURE mode, a selected pin edge does four things on one edge: it copies the count into the capture register (read at address 3), clears the counter to 0x00, and sets flag bits 0 and 1.
- R7: Flag bit 2 (error) is set in two cases: a trigger arrives while flag bit 1 is already set, or an overflow occurs in CAPTURE mode.
- R8: Flag bits 1 and 2 are cleared only by reset or by writing 0 to them at address 2. If a set event and a clear write fall on the same edge, the set wins.
- R9: Any write to the control register (address 1) with mode 11 clears the counter to 0x00. On the edge of a control or preset write, no tick, overflow or capture takes effect.
- R10: Reads: address 0 returns the count, 1 the control byte as written, 2 the flags {00000, error, status, irq}, 3 the capture register. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| evt_pin | input | 1 | Asynchronous event / trigger pin |
| irq_flag | output | 1 | Sticky interrupt request |

## Verification
Register writes, prescaled ticks, overflows and captures all take effect on the clock edge that samples them. Their results show on the read port during the following cycle. A pin change reaches the counter or the flags only on the third clock edge after it, because of the two synchronizer stages and the edge-detector sample. The bench's reference model holds its own delay line for the pin, so it expects each result at the edge where it is due. It reads all four addresses at every falling edge, after the outputs have settled. The hand-written checks wait a counted number of falling edges, worked out from these same latencies.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_FREE    = 2'b00,
        MODE_RELOAD  = 2'b01,
        MODE_EVENT   = 2'b10,
        MODE_CAPTURE = 2'b11
    } tmr_mode_e;

    localparam logic [1:0] A_COUNT = 2'd0;
    localparam logic [1:0] A_CTRL  = 2'd1;
    localparam logic [1:0] A_FLAGS = 2'd2;
    localparam logic [1:0] A_CAPT  = 2'd3;

    localparam int FL_IRQ = 0;
    localparam int FL_STS = 1;
    localparam int FL_ERR = 2;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low 'sel' bits of the mask are ones; tick when they are all set.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    assign tick = ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_en,
    input  logic fall_en,
    output logic pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign pulse = (rise_en &  sync_q[STAGES-1] & ~last_q)
                 | (fall_en & ~sync_q[STAGES-1] &  last_q);
endmodule

// File: rtl/tick_capture_timer.sv
`timescale 1ns/1ps
module tick_capture_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_SEL_W   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             evt_pin,
    output logic             irq_flag
);
    localparam int PS_LO = 2;
    localparam int PS_HI = PS_LO + PSC_SEL_W - 1;
    localparam int ES_LO = PS_HI + 1;
    localparam int ES_HI = ES_LO + 1;

    tmr_mode_e        mode_q, mode_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, preset_q, cap_q, ctrl_q;
    logic [CNT_W-1:0] fl_q, fl_d, fl_set, fl_keep, reload_val;
    logic             wr_count, wr_ctrl, wr_flags, busy;
    logic             psc_tick, edge_pulse, cnt_tick, trig;
    logic             cap_evt, ovf_evt, at_max;

    assign wr_count = wr_en && (wr_addr == A_COUNT);
    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_flags = wr_en && (wr_addr == A_FLAGS);

    tmr_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_ctrl),
        .sel     (ctrl_q[PS_HI:PS_LO]),
        .tick    (psc_tick)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (evt_pin),
        .rise_en (ctrl_q[ES_LO]),
        .fall_en (ctrl_q[ES_HI]),
        .pulse   (edge_pulse)
    );

    // State: next mode
    always_comb begin
        mode_d = mode_q;
        if (wr_ctrl) mode_d = tmr_mode_e'(wr_data[1:0]);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_FREE;
        else        mode_q <= mode_d;
    end

    // Tick source and events
    assign at_max   = (cnt_q == '1);
    assign cnt_tick = (mode_q == MODE_EVENT) ? edge_pulse : psc_tick;
    assign trig     = (mode_q == MODE_CAPTURE) && edge_pulse;
    assign busy     = wr_ctrl || wr_count;
    assign cap_evt  = trig && !busy;
    assign ovf_evt  = cnt_tick && at_max && !busy && !cap_evt;

    always_comb begin
        unique case (mode_q)
            MODE_RELOAD:  reload_val = preset_q;
            MODE_FREE:    reload_val = '0;
            MODE_EVENT:   reload_val = '0;
            MODE_CAPTURE: reload_val = '0;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (wr_ctrl) begin
            if (wr_data[1:0] == MODE_CAPTURE) cnt_d = '0;
        end else if (wr_count) begin
            cnt_d = wr_data;
        end else if (cap_evt) begin
            cnt_d = '0;
        end else if (cnt_tick) begin
            cnt_d = at_max ? reload_val : cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        fl_set         = '0;
        fl_set[FL_IRQ] = cap_evt || ovf_evt;
        fl_set[FL_STS] = cap_evt;
        fl_set[FL_ERR] = (cap_evt && fl_q[FL_STS])
                       || (ovf_evt && (mode_q == MODE_CAPTURE));
        fl_keep        = wr_flags ? wr_data : '1;
        fl_d           = fl_set | (fl_q & fl_keep);
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            fl_q     <= '0;
            ctrl_q   <= '0;
            preset_q <= '0;
            cap_q    <= '0;
        end else begin
            cnt_q <= cnt_d;
            fl_q  <= fl_d;
            if (wr_ctrl)  ctrl_q   <= wr_data;
            if (wr_count) preset_q <= wr_data;
            if (cap_evt)  cap_q    <= cnt_q;
        end
    end

    assign irq_flag = fl_q[FL_IRQ];

    always_comb begin
        unique case (rd_addr)
            A_COUNT: rd_data = cnt_q;
            A_CTRL:  rd_data = ctrl_q;
            A_FLAGS: rd_data = fl_q;
            A_CAPT:  rd_data = cap_q;
        endcase
    end
endmodule

// File: rtl/tick_capture_timer_chk.sv
`timescale 1ns/1ps
module tick_capture_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [1:0]       wr_lo,
    input logic             cnt_tick,
    input logic             trig,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] preset_q,
    input logic             irq,
    input logic             sts,
    input logic             err
);
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cnt_tick && !trig) |=> $stable(cnt_q));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt_tick && !trig && cnt_q != '1)
        |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

    p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt_tick && cnt_q == '1 && mode == 2'b00) |=> (cnt_q == '0));

    p_reload_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && cnt_tick && cnt_q == '1 && mode == 2'b01) |=> (cnt_q == preset_q));

    p_irq_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && wr_addr == 2'd2 && !wr_lo[0])) |=> irq);

    p_capture_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && trig) |=> (cnt_q == '0 && sts && irq));

    p_capture_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && sts && !(wr_en && !wr_addr[1])) |=> err);

    p_enter_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_lo == 2'b11) |=> (cnt_q == '0));
endmodule

bind tick_capture_timer tick_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_lo    (wr_data[1:0]),
    .cnt_tick (cnt_tick),
    .trig     (trig),
    .mode     (mode_q),
    .cnt_q    (cnt_q),
    .preset_q (preset_q),
    .irq      (fl_q[0]),
    .sts      (fl_q[1]),
    .err      (fl_q[2])
);

// File: tb/tick_capture_timer_test.sv
`timescale 1ns/1ps
module tick_capture_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       evt_pin = 1'b0;
    logic       irq_flag;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    tick_capture_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_pin(evt_pin), .irq_flag(irq_flag)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Reference model state
    int m_cnt, m_preset, m_cap, m_ctrl, m_pcnt;
    bit m_irq, m_sts, m_err, m_s0, m_s1, m_last;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_preset = 0; m_cap = 0; m_ctrl = 0; m_pcnt = 0;
            m_irq = 0; m_sts = 0; m_err = 0; m_s0 = 0; m_s1 = 0; m_last = 0;
        end else begin
            int mode, ratio;
            bit pulse, tick, wc, wp, wf, busy, cap, ovf, eset;
            mode  = m_ctrl & 3;
            ratio = 1 << ((m_ctrl >> 2) & 7);
            pulse = (((m_ctrl >> 5) & 1) == 1 && m_s1 && !m_last)
                 || (((m_ctrl >> 6) & 1) == 1 && !m_s1 && m_last);
            tick  = (mode == 2) ? pulse : ((m_pcnt % ratio) == ratio - 1);
            wc = wr_en && wr_addr == 2'd1;
            wp = wr_en && wr_addr == 2'd0;
            wf = wr_en && wr_addr == 2'd2;
            busy = wc || wp;
            cap  = (mode == 3) && pulse && !busy;
            ovf  = tick && m_cnt == 255 && !busy && !cap;
            eset = (cap && m_sts) || (ovf && mode == 3);
            if (wf) begin
                if (!wr_data[0]) m_irq = 0;
                if (!wr_data[1]) m_sts = 0;
                if (!wr_data[2]) m_err = 0;
            end
            if (cap || ovf) m_irq = 1;
            if (cap) m_sts = 1;
            if (eset) m_err = 1;
            if (cap) m_cap = m_cnt;
            if (wc) begin
                if (wr_data[1:0] == 2'b11) m_cnt = 0;
            end else if (wp) m_cnt = wr_data;
            else if (cap) m_cnt = 0;
            else if (tick) m_cnt = (m_cnt == 255) ? ((mode == 1) ? m_preset : 0) : m_cnt + 1;
            if (wp) m_preset = wr_data;
            if (wc) m_ctrl = wr_data;
            m_pcnt = wc ? 0 : (m_pcnt + 1) % 128;
            m_last = m_s1; m_s1 = m_s0; m_s0 = evt_pin;
        end
    end

    // Per-cycle comparison of every readable register
    int d_cnt, d_ctrl, d_flags, d_cap;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int a = 0; a < 4; a++) begin
                rd_addr = a[1:0];
                #1;
                case (a)
                    0: begin d_cnt = rd_data;   check("R2 count", d_cnt, m_cnt); end
                    1: begin d_ctrl = rd_data;  check("R10 control", d_ctrl, m_ctrl); end
                    2: begin d_flags = rd_data; check("R4 flags", d_flags, {m_err, m_sts, m_irq}); end
                    default: begin d_cap = rd_data; check("R6 capture", d_cap, m_cap); end
                endcase
            end
            check("R4 irq pin", irq_flag, m_irq);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #4.5;
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; evt_pin = 1'b1;
            repeat (4) @(posedge clk);
            #1; evt_pin = 1'b0;
            repeat (4) @(posedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle(1);
        check("R1 reset count", d_cnt, 0);
        check("R1 reset flags", d_flags, 0);
        check("R1 reset capture", d_cap, 0);
        check("R1 reset irq", irq_flag, 0);

        // Free-running, divide by 1
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h10);
        settle(1); check("R2 preset load", d_cnt, 8'h10);
        settle(5); check("R2 count by one", d_cnt, 8'h15);

        wr(2'd0, 8'hFE);
        settle(3);
        check("R3 free wrap", d_cnt, 8'h00);
        check("R4 irq on overflow", irq_flag, 1);
        wr(2'd2, 8'h01); settle(1);
        check("R4 write one keeps irq", irq_flag, 1);
        wr(2'd2, 8'h00); settle(1);
        check("R4 write zero clears irq", irq_flag, 0);

        // Reload mode
        wr(2'd1, 8'h01);
        wr(2'd0, 8'hFD);
        settle(4); check("R3 reload wrap", d_cnt, 8'hFD);

        // Prescaler divide by 4
        wr(2'd1, 8'h08);
        wr(2'd0, 8'h20);
        settle(17); check("R2 divide by 4", d_cnt, 8'h24);

        // Event counting, each edge selection
        wr(2'd1, 8'h22); wr(2'd0, 8'h00);
        pin_pulses(3); settle(2); check("R5 rising edges", d_cnt, 3);
        wr(2'd1, 8'h42); wr(2'd0, 8'h00);
        pin_pulses(3); settle(2); check("R5 falling edges", d_cnt, 3);
        wr(2'd1, 8'h62); wr(2'd0, 8'h00);
        pin_pulses(3); settle(2); check("R5 both edges", d_cnt, 6);
        wr(2'd1, 8'h02); wr(2'd0, 8'h00);
        pin_pulses(2); settle(2); check("R5 no edge selected", d_cnt, 0);

        // Capture mode
        wr(2'd1, 8'h00); wr(2'd0, 8'h55);
        wr(2'd1, 8'h23); settle(1);
        check("R9 enter capture clears", d_cnt, 0);
        wr(2'd2, 8'h00);
        repeat (20) @(posedge clk);
        pin_pulses(1); settle(1);
        check("R6 flags after capture", d_flags, 8'h03);
        check("R6 captured count", d_cap, m_cap);
        check("R6 counter restarted", (d_cnt < 12) ? 1 : 0, 1);
        pin_pulses(1); settle(1);
        check("R7 error on pending capture", d_flags, 8'h07);
        wr(2'd2, 8'h00); settle(1);
        check("R8 flags cleared", d_flags, 8'h00);
        repeat (300) @(posedge clk);
        settle(1);
        check("R7 error on capture overflow", d_flags, 8'h05);
        wr(2'd2, 8'h01); settle(1);
        check("R8 error cleared irq kept", d_flags, 8'h01);

        // Register map
        begin
            int saved;
            saved = d_cap;
            wr(2'd3, 8'hAA); settle(1);
            check("R10 capture write ignored", d_cap, saved);
            check("R10 control readback", d_ctrl, 8'h23);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule